// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a phase-locked loop has reached frequency lock. It watches the divided reference and the divided feedback clock at the phase-detector rate, and samples both into the system clock domain. It counts rising edges of each over a window of a fixed number of reference cycles. At the end of each window it forms the absolute difference between the two counts.

Two thresholds, both given in parts per million of the window, set the behaviour. A difference at or below the tighter one declares lock. A difference above the looser one drops lock. A difference between the two leaves the previous decision as it was, so a loop that is only marginally settled does not chatter. The result appears on an active-low flag, where low means locked. The flag is forced high during reset and stays high until at least one full window has been measured. The flag only reports lock state and drives nothing else in the loop.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first full window has closed, `lock_n` is high (unlocked).
- R2: When a window closes with |reference count - feedback count| no greater than LOCK_LIM = WIN_REF_CYCLES*LOCK_PPM/1e6 counts, `lock_n` goes low.
- R3: While locked, a window whose difference exceeds LOCK_LIM but is no greater than UNLOCK_LIM = WIN_REF_CYCLES*UNLOCK_PPM/1e6 leaves `lock_n` low.
- R4: When a window closes with a difference greater than UNLOCK_LIM, `lock_n` goes high.
- R5: While unlocked, a window whose difference lies above LOCK_LIM and no greater than UNLOCK_LIM leaves `lock_n` high.
- R6: The decision depends only on the magnitude of the difference, whether the feedback runs fast or slow.
- R7: `lock_n` is re-evaluated only once per window, and a single frequency step produces at most one transition of `lock_n`.
- R8: A window opens on a reference rising edge and closes on the WIN_REF_CYCLES-th reference rising edge after it. A feedback edge that falls in the same sample as the closing edge is counted in the closing window, exactly once.
- R9: The feedback counter saturates at its maximum instead of wrapping, so a feedback far faster than the reference always reads as a large difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both phase-detector-rate clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Divided reference clock, asynchronous to `clk` |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous to `clk` |
| lock_n | output | 1 | Lock flag, low when frequency-locked |

## Verification
The two events that can fall in the same cycle are a feedback rising edge and the reference edge that closes a window. To force them together, the bench drives a feedback waveform identical to the reference, so that every feedback edge coincides with a reference edge. A second instance is built with a lock limit of zero counts and an unlock limit of one count. That instance may report lock only if each coincident edge lands in exactly one window, so a dropped or double-counted edge at the boundary keeps it unlocked.

// File: rtl/fld_pkg.sv
// Shared types for the frequency lock detector.
package fld_pkg;
    // Lock decision held by the hysteresis stage.
    typedef enum logic {
        LK_OFF = 1'b0,
        LK_ON  = 1'b1
    } lock_state_t;
endpackage

// File: rtl/fld_edge_sync.sv
// Brings an asynchronous clock-like level into the clk domain through a
// flop chain of STAGES flops and emits a one-cycle pulse on each rising edge.
// Assumes the input stays high and low for at least one clk period each.
module fld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchronizer chain plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], lvl_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    // A rising-edge pulse never lasts two cycles.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fld_window.sv
// Counts reference and feedback edges over a window of WIN reference cycles.
// The first reference edge after reset opens the first window. Each closing
// reference edge also opens the next window. At the close it publishes the
// feedback count, including a feedback edge in the same cycle, with a one-cycle
// done pulse.
module fld_window #(
    parameter int WIN  = 10000,
    parameter int FB_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_rise_i,
    input  logic            fb_rise_i,
    output logic            done_o,
    output logic [FB_W-1:0] fb_total_o
);
    localparam int REF_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(WIN - 1);
    localparam logic [FB_W-1:0]  FB_MAX   = '1;

    logic             run_q;
    logic [REF_W-1:0] ref_cnt_q;
    logic [FB_W-1:0]  fb_cnt_q;
    logic [FB_W-1:0]  fb_next;

    // Saturating feedback increment, including an edge in the current cycle.
    always_comb begin
        if (fb_cnt_q == FB_MAX) fb_next = FB_MAX;
        else                    fb_next = fb_cnt_q + FB_W'(fb_rise_i);
    end

    // Window sequencing: arm on the first edge, then count and close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            ref_cnt_q  <= '0;
            fb_cnt_q   <= '0;
            done_o     <= 1'b0;
            fb_total_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (!run_q) begin
                if (ref_rise_i) begin
                    run_q     <= 1'b1;
                    ref_cnt_q <= '0;
                    fb_cnt_q  <= '0;
                end
            end else if (ref_rise_i && ref_cnt_q == REF_LAST) begin
                done_o     <= 1'b1;
                fb_total_o <= fb_next;
                ref_cnt_q  <= '0;
                fb_cnt_q   <= '0;
            end else begin
                if (ref_rise_i) ref_cnt_q <= ref_cnt_q + 1'b1;
                fb_cnt_q <= fb_next;
            end
        end
    end

    // A saturated feedback count only stays saturated or restarts.
    a_r9_fb_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        fb_cnt_q == FB_MAX |=> (fb_cnt_q == FB_MAX) || (fb_cnt_q == '0));

    // No window can close before the window has been armed.
    a_r1_no_early_close: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !done_o);
endmodule

// File: rtl/fld_judge.sv
// Turns each closed window's feedback count into a lock decision, with
// hysteresis between the lock and unlock limits. The decision changes only on
// the cycle after a window closes.
module fld_judge
    import fld_pkg::*;
#(
    parameter int WIN      = 10000,
    parameter int FB_W     = 15,
    parameter int LOCK_LIM = 5,
    parameter int UNLK_LIM = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_i,
    input  logic [FB_W-1:0] fb_total_i,
    output logic            lock_n_o
);
    localparam logic [FB_W-1:0] WIN_V  = FB_W'(WIN);
    localparam logic [FB_W-1:0] LOCK_V = FB_W'(LOCK_LIM);
    localparam logic [FB_W-1:0] UNLK_V = FB_W'(UNLK_LIM);

    lock_state_t     state_q;
    logic [FB_W-1:0] gap;

    // Magnitude of the count difference; the reference count is always WIN.
    always_comb begin
        if (fb_total_i >= WIN_V) gap = fb_total_i - WIN_V;
        else                     gap = WIN_V - fb_total_i;
    end

    // Hysteresis decision, taken once per closed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_OFF;
        end else if (done_i) begin
            if (gap <= LOCK_V)      state_q <= LK_ON;
            else if (gap > UNLK_V)  state_q <= LK_OFF;
        end
    end

    assign lock_n_o = (state_q != LK_ON);

    a_r1_reset_unlocked: assert property (@(posedge clk)
        !rst_n |=> lock_n_o);

    a_r2_lock_small_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && gap <= LOCK_V) |=> !lock_n_o);

    a_r4_unlock_large_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && gap > UNLK_V) |=> lock_n_o);

    a_r7_change_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_n_o) |-> $past(done_i));
endmodule

// File: rtl/freq_lock_detect.sv
// Frequency lock detector: edge counting over a reference-cycle window with
// parts-per-million lock and unlock limits. Assumes clk runs at least twice as
// fast as either input clock and that the limits map to whole counts.
module freq_lock_detect #(
    parameter int WIN_REF_CYCLES = 10000,
    parameter int LOCK_PPM       = 500,
    parameter int UNLOCK_PPM     = 800,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk_i,
    input  logic fb_clk_i,
    output logic lock_n
);
    localparam int  FB_W     = $clog2(WIN_REF_CYCLES + 1) + 1;
    localparam longint LOCK_L = (longint'(WIN_REF_CYCLES) * LOCK_PPM) / 1000000;
    localparam longint UNLK_L = (longint'(WIN_REF_CYCLES) * UNLOCK_PPM) / 1000000;

    logic [1:0]      rise;
    logic [1:0]      lvl;
    logic            win_done;
    logic [FB_W-1:0] fb_total;

    assign lvl = {fb_clk_i, ref_clk_i};

    // One synchronizer per input clock: index 0 reference, index 1 feedback.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        fld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[g]),
            .rise_o (rise[g])
        );
    end

    fld_window #(.WIN(WIN_REF_CYCLES), .FB_W(FB_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise_i (rise[0]),
        .fb_rise_i  (rise[1]),
        .done_o     (win_done),
        .fb_total_o (fb_total)
    );

    fld_judge #(
        .WIN      (WIN_REF_CYCLES),
        .FB_W     (FB_W),
        .LOCK_LIM (int'(LOCK_L)),
        .UNLK_LIM (int'(UNLK_L))
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (win_done),
        .fb_total_i (fb_total),
        .lock_n_o   (lock_n)
    );
endmodule

// File: tb/freq_lock_detect_test.sv
// Directed bench. Window of 100 reference cycles; uut limits 5/8 counts,
// uut_exact limits 0/1 counts. Reference period is 8 clk cycles, so one window
// is 800 cycles. The feedback has fb_step/800 cycles per clk, which gives
// exactly fb_step feedback edges per window.
module freq_lock_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic fb_clk = 1'b0;
    logic lock_n, lock_n_exact;
    int   ref_ph = 0, fb_ph = 0, fb_step = 100;
    int   n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    freq_lock_detect #(.WIN_REF_CYCLES(100), .LOCK_PPM(50000), .UNLOCK_PPM(80000)) uut (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk), .lock_n(lock_n));

    freq_lock_detect #(.WIN_REF_CYCLES(100), .LOCK_PPM(0), .UNLOCK_PPM(10000)) uut_exact (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk), .lock_n(lock_n_exact));

    // Clock-pattern generator, updated away from the sampling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            ref_ph = 0; fb_ph = 0;
        end else begin
            ref_ph = (ref_ph + 100) % 800;
            fb_ph  = (fb_ph + fb_step) % 800;
        end
        ref_clk = (ref_ph >= 400);
        fb_clk  = (fb_ph >= 400);
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_n actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_step(input int s);
        @(posedge clk);
        fb_step = s;
    endtask

    // R1/R2/R8: reset state, no lock before a full window, then lock.
    task automatic t_reset_and_first_lock();
        rst_n = 1'b0;
        wait_cyc(5);
        check("R1 in reset", lock_n, 1'b1);
        check("R1 in reset exact", lock_n_exact, 1'b1);
        @(posedge clk); rst_n = 1'b1;
        wait_cyc(600);
        check("R1 before first window", lock_n, 1'b1);
        wait_cyc(400);
        check("R2 lock after first window", lock_n, 1'b0);
        check("R8 coincident edges counted once", lock_n_exact, 1'b0);
    endtask

    // R2/R6/R8: small offsets either way stay locked.
    task automatic t_small_offsets();
        set_step(103); wait_cyc(2400);
        check("R2 fast by 3", lock_n, 1'b0);
        check("R8 tight instance sees 3 counts", lock_n_exact, 1'b1);
        set_step(97); wait_cyc(2400);
        check("R6 slow by 3", lock_n, 1'b0);
    endtask

    // R3/R6: inside the hysteresis band from the locked state.
    task automatic t_band_locked();
        set_step(107); wait_cyc(2400);
        check("R3 band keeps lock fast", lock_n, 1'b0);
        set_step(93); wait_cyc(2400);
        check("R6 band keeps lock slow", lock_n, 1'b0);
    endtask

    // R4/R7: one step past the unlock limit gives one transition.
    task automatic t_unlock_single_edge();
        int flips = 0;
        logic prev;
        set_step(100); wait_cyc(2400);
        check("R2 relock", lock_n, 1'b0);
        set_step(115);
        prev = lock_n;
        for (int i = 0; i < 2400; i++) begin
            @(negedge clk);
            if (lock_n !== prev) flips++;
            prev = lock_n;
        end
        n_chk++;
        if (flips != 1) begin
            n_bad++;
            $display("FAIL R7: transitions actual %0d expected 1", flips);
        end
        check("R4 unlock fast by 15", lock_n, 1'b1);
    endtask

    // R5/R6/R2: band from unlocked, slow unlock, regain lock.
    task automatic t_band_unlocked();
        set_step(107); wait_cyc(2400);
        check("R5 band keeps unlock", lock_n, 1'b1);
        set_step(85); wait_cyc(2400);
        check("R6 unlock slow by 15", lock_n, 1'b1);
        set_step(104); wait_cyc(2400);
        check("R2 regain lock", lock_n, 1'b0);
    endtask

    // R4/R9: stopped feedback, then much faster feedback that would wrap.
    task automatic t_extremes();
        set_step(0); wait_cyc(2400);
        check("R4 stopped feedback", lock_n, 1'b1);
        set_step(100); wait_cyc(2400);
        check("R2 lock before overspeed", lock_n, 1'b0);
        set_step(356); wait_cyc(3200);
        check("R9 overspeed saturates", lock_n, 1'b1);
    endtask

    // R1: reset while locked forces unlocked until a new window closes.
    task automatic t_reset_while_locked();
        set_step(100); wait_cyc(2400);
        check("R2 locked before reset", lock_n, 1'b0);
        @(posedge clk); rst_n = 1'b0;
        wait_cyc(3);
        check("R1 reset forces unlock", lock_n, 1'b1);
        @(posedge clk); rst_n = 1'b1;
        wait_cyc(500);
        check("R1 unlocked after reset release", lock_n, 1'b1);
    endtask

    initial begin
        t_reset_and_first_lock();
        t_small_offsets();
        t_band_locked();
        t_unlock_single_edge();
        t_band_unlocked();
        t_extremes();
        t_reset_while_locked();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run still active, expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule